// File: doc/BRIEF.md
# Cross-Triggered Clocking-Engine Sequencer

This block steps through a stream of preloaded 32-bit instructions for one clocking engine and turns pattern words into clock-line levels with a hold time. Several such engines share one wired-OR "busy" line. Two in-stream instructions let them start together. A NOTDONE word raises this engine's busy drive. A WAITDONE word drops the engine's own drive and then parks the engine until nobody on the line is busy. Once the line is free, a per-engine phase offset is counted. After that offset the next instruction runs, so each engine can sample a fixed number of clocks after the shared release.

Each engine has its own go input; there is no broadcast go. Instructions must already sit in a show-ahead FIFO when go arrives. An engine that is wired to the line but not part of the current readout has its enable bit cleared. It then never pulls the line busy, and its own WAITDONE words pass straight through. A sequence may hold many NOTDONE/WAITDONE pairs, for example one per pixel row, so that engines running from different oscillators are realigned often. One delay count equals one clock cycle, which is 10 ns at the intended 100 MHz system clock.

Top module: `xtrig_seq`

## Requirements
- R1: After reset, `running`, `bus_drv`, `fifo_rd`, `strobe` and `uflow_err` are all 0.
- R2: While idle, no FIFO word is read until `go` is seen. With `go` high in an idle cycle, the first word is read in the following cycle. A `go` seen while the engine is running or stopped on an error has no effect.
- R3: A word whose bits 31:28 are 0 is a pattern word. In the cycle after it is read, `clk_lines` shows bits 27:16 and `strobe` is high for exactly one cycle. The next word is read max(H,1) cycles after it, where H is bits 15:0.
- R4: A word with bits 31:28 equal to 1 (NOTDONE) sets the engine's busy drive from the next cycle, while `xt_en` is high. The next word is read one cycle later.
- R5: A word with bits 31:28 equal to 2 (WAITDONE), with `xt_en` high, clears the busy drive from the next cycle. The engine then reads nothing until the synchronized line is low, and it checks the line only after a settle window of SYNC_STAGES cycles. With no other participant busy, the next word is read SYNC_STAGES+2 cycles after the WAITDONE read. When another participant releases the line later, the next word is read SYNC_STAGES+2 cycles after the line falls.
- R6: The value on `phase_dly` is captured in the cycle the rendezvous completes. That value D delays the next read by exactly D cycles beyond the zero-delay timing. D = 0 adds nothing.
- R7: With `xt_en` low, `bus_drv` stays 0 whatever the sequence has set. A WAITDONE then takes one cycle with no stall and no phase delay, even if other participants hold the line busy.
- R8: A word with bits 31:28 equal to 3 (END) returns the engine to idle and leaves the busy drive unchanged. Words behind it stay unread until the next `go`.
- R9: If the FIFO is empty when the next word is due, the engine stops, keeps its busy drive and raises `uflow_err`. The flag stays high and the engine stays stopped until `err_clr` is pulsed. That pulse clears the flag and returns the engine to idle.
- R10: Repeated NOTDONE/WAITDONE pairs in one sequence each perform a full rendezvous with the same timing as R5 and R6.
- R11: A word with bits 31:28 in the range 4 to 15 is skipped, and the next word is read one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Per-engine start request |
| xt_en | input | 1 | Take part in the shared busy line |
| fifo_empty | input | 1 | Instruction FIFO has no word |
| fifo_data | input | 32 | Show-ahead head word of the FIFO |
| fifo_rd | output | 1 | Pop the head word this cycle |
| bus_in | input | 1 | Observed wired-OR busy line (asynchronous) |
| bus_drv | output | 1 | This engine's busy drive onto the line |
| phase_dly | input | DLY_W | Cycles to wait after a rendezvous |
| err_clr | input | 1 | Clears the underflow flag and leaves the stopped state |
| clk_lines | output | 12 | Clock-line levels of the current pattern |
| strobe | output | 1 | One-cycle pulse when new levels are applied |
| running | output | 1 | Engine is not idle |
| uflow_err | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench builds the block with DLY_W = 16 and SYNC_STAGES = 2, with three further participants modelled as a wired OR on the line. Two synchronizer stages fix the rendezvous exit at four cycles. This makes the spacing between successive strobes exactly predictable, both through rendezvous with phase delays of 0 and 3 and after another participant releases late. A 16-bit delay field also covers the whole hold-count encoding, so long, zero and unit holds can all be placed in one run.

// File: rtl/xtrig_pkg.sv
// Shared types for the cross-triggered sequencer.
// Assumes a fixed 32-bit instruction word: opcode in the top nibble,
// clock-line levels in the middle, hold count in the low half.
package xtrig_pkg;

    localparam int WORD_W  = 32;
    localparam int LINES_W = 12;
    localparam int HOLD_W  = 16;

    localparam logic [3:0] OP_PATTERN  = 4'd0;
    localparam logic [3:0] OP_NOTDONE  = 4'd1;
    localparam logic [3:0] OP_WAITDONE = 4'd2;
    localparam logic [3:0] OP_END      = 4'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HOLD,
        ST_WAIT,
        ST_DELAY,
        ST_HALT
    } seq_state_e;

    // Opcode nibble of an instruction word
    function automatic logic [3:0] word_op(input logic [WORD_W-1:0] w);
        return w[31:28];
    endfunction

    // Clock-line field of a pattern word
    function automatic logic [LINES_W-1:0] word_lines(input logic [WORD_W-1:0] w);
        return w[27:16];
    endfunction

    // Hold-count field of a pattern word
    function automatic logic [HOLD_W-1:0] word_hold(input logic [WORD_W-1:0] w);
        return w[15:0];
    endfunction

endpackage

// File: rtl/xtrig_sync.sv
// Multi-flop synchronizer for the asynchronous shared busy line.
// Assumes STAGES >= 1; output lags the input by STAGES clock edges.
module xtrig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the line through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xtrig_downcnt.sv
// Loadable down-counter used for pattern hold and post-release phase delay.
// Assumes the caller loads a nonzero value and decrements while waiting;
// `last` is high in the final counted cycle (count equals one).
module xtrig_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    logic [W-1:0] cnt;

    // Load a new count or step toward zero, never below it
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (dec && cnt != '0)   cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0));  // R6

endmodule

// File: rtl/xtrig_seq.sv
// Instruction sequencer for one clocking engine on a shared busy line.
// Reads a show-ahead FIFO after go, applies pattern words with hold counts,
// raises or drops its busy drive on NOTDONE/WAITDONE, waits for the line to
// clear, then counts a per-engine phase delay. Assumes bus_in is the
// asynchronous wired OR of all participants, including this engine.
module xtrig_seq
    import xtrig_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic                 xt_en,
    input  logic                 fifo_empty,
    input  logic [WORD_W-1:0]    fifo_data,
    output logic                 fifo_rd,
    input  logic                 bus_in,
    output logic                 bus_drv,
    input  logic [DLY_W-1:0]     phase_dly,
    input  logic                 err_clr,
    output logic [LINES_W-1:0]   clk_lines,
    output logic                 strobe,
    output logic                 running,
    output logic                 uflow_err
);

    localparam int SETTLE_W = $clog2(SYNC_STAGES + 1);

    seq_state_e           state_q, state_d;
    logic                 drive_q, err_q, strobe_q;
    logic [LINES_W-1:0]   lines_q;
    logic [SETTLE_W-1:0]  settle_q;
    logic                 bus_seen, hold_last, dly_last;
    logic [3:0]           op;
    logic [LINES_W-1:0]   w_lines;
    logic [HOLD_W-1:0]    w_hold;
    logic                 pop, long_hold, hold_ld, release_ev, dly_ld;

    assign op      = word_op(fifo_data);
    assign w_lines = word_lines(fifo_data);
    assign w_hold  = word_hold(fifo_data);

    assign pop        = (state_q == ST_FETCH) && !fifo_empty;
    assign long_hold  = (w_hold > HOLD_W'(1));
    assign hold_ld    = pop && (op == OP_PATTERN) && long_hold;
    assign release_ev = (state_q == ST_WAIT) &&
                        (!xt_en || ((settle_q == '0) && !bus_seen));
    assign dly_ld     = release_ev && (phase_dly != '0);

    xtrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (bus_seen)
    );

    xtrig_downcnt #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_ld),
        .load_val (w_hold - HOLD_W'(1)),
        .dec      (state_q == ST_HOLD),
        .last     (hold_last)
    );

    xtrig_downcnt #(.W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_ld),
        .load_val (phase_dly),
        .dec      (state_q == ST_DELAY),
        .last     (dly_last)
    );

    // Next-state decision for the sequencer
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (go) state_d = ST_FETCH;
            ST_FETCH: begin
                if (fifo_empty) begin
                    state_d = ST_HALT;
                end else begin
                    case (op)
                        OP_PATTERN:  state_d = long_hold ? ST_HOLD : ST_FETCH;
                        OP_WAITDONE: state_d = xt_en ? ST_WAIT : ST_FETCH;
                        OP_END:      state_d = ST_IDLE;
                        default:     state_d = ST_FETCH;
                    endcase
                end
            end
            ST_HOLD:  if (hold_last) state_d = ST_FETCH;
            ST_WAIT:  if (release_ev) state_d = dly_ld ? ST_DELAY : ST_FETCH;
            ST_DELAY: if (dly_last) state_d = ST_FETCH;
            ST_HALT:  if (err_clr) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Busy drive: raised by NOTDONE, dropped by WAITDONE, otherwise held
    always_ff @(posedge clk) begin
        if (!rst_n)                        drive_q <= 1'b0;
        else if (pop && op == OP_NOTDONE)  drive_q <= 1'b1;
        else if (pop && op == OP_WAITDONE) drive_q <= 1'b0;
    end

    // Settle window so the synchronizer reflects the line after our own drop
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle_q <= '0;
        else if (pop && op == OP_WAITDONE)
            settle_q <= SETTLE_W'(SYNC_STAGES);
        else if (state_q == ST_WAIT && settle_q != '0)
            settle_q <= settle_q - SETTLE_W'(1);
    end

    // Clock-line register and one-cycle apply strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= pop && (op == OP_PATTERN);
            if (pop && op == OP_PATTERN) lines_q <= w_lines;
        end
    end

    // Sticky underflow flag
    always_ff @(posedge clk) begin
        if (!rst_n)                               err_q <= 1'b0;
        else if (state_q == ST_FETCH && fifo_empty) err_q <= 1'b1;
        else if (err_clr)                         err_q <= 1'b0;
    end

    assign fifo_rd   = pop;
    assign bus_drv   = drive_q & xt_en;
    assign clk_lines = lines_q;
    assign strobe    = strobe_q;
    assign running   = (state_q != ST_IDLE);
    assign uflow_err = err_q;

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);  // R9

    AST_STROBE_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(fifo_rd));  // R3

    AST_IDLE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_IDLE) && !$past(go)) |-> (state_q == ST_IDLE));  // R2

    AST_WAIT_EXIT_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_WAIT) && state_q != ST_WAIT)
            |-> ($past(!bus_seen) || $past(!xt_en)));  // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(uflow_err) && !$past(err_clr)) |-> uflow_err);  // R9

    AST_HALT_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && $past(state_q == ST_HALT)) |-> $stable(drive_q));  // R9

endmodule

// File: tb/sim_xtrig_seq.sv
`timescale 1ns/1ps
module sim_xtrig_seq;

    localparam int DLY_W = 16;
    localparam int SYNC  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        xt_en = 1'b0;
    logic        err_clr = 1'b0;
    logic [2:0]  others = '0;
    logic [DLY_W-1:0] phase_dly = '0;
    logic        fifo_empty, fifo_rd, bus_in, bus_drv, strobe, running, uflow_err;
    logic [31:0] fifo_data;
    logic [11:0] clk_lines;

    logic [31:0] fmem [0:255];
    int wp = 0;
    int rp = 0;

    int n_chk = 0;
    int n_err = 0;
    int since = 0;
    int acc = 0;
    bit done = 0;

    logic [11:0] exp_lines[$];
    int          exp_gap[$];
    string       exp_tag[$];

    always #2.5 clk = ~clk;

    assign fifo_empty = (wp == rp);
    assign fifo_data  = fmem[rp & 255];
    assign bus_in     = bus_drv | (|others);

    always @(posedge clk) if (fifo_rd) rp <= rp + 1;

    xtrig_seq #(.DLY_W(DLY_W), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .xt_en(xt_en),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .bus_in(bus_in), .bus_drv(bus_drv), .phase_dly(phase_dly),
        .err_clr(err_clr), .clk_lines(clk_lines), .strobe(strobe),
        .running(running), .uflow_err(uflow_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        fmem[wp & 255] = w;
        wp++;
    endtask

    // Driver: pattern word plus its expected strobe spacing
    task automatic add_pat(input logic [11:0] lines, input int hold, input string tag);
        push_word({4'd0, lines, 16'(hold)});
        exp_lines.push_back(lines);
        exp_gap.push_back(acc);
        exp_tag.push_back(tag);
        acc = (hold > 1) ? hold : 1;
    endtask

    task automatic add_op(input logic [3:0] opc, input int cost);
        push_word({opc, 28'd0});
        acc += cost;
    endtask

    task automatic start;
        @(negedge clk);
        go = 1'b1;
        since = 0;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!running) break;
        end
    endtask

    // Monitor: compare each strobe against the scoreboard
    always @(posedge clk) begin
        #1;
        since = since + 1;
        if (rst_n && strobe) begin
            if (exp_lines.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", int'(clk_lines), 0);
            end else begin
                logic [11:0] el;
                int eg;
                string et;
                el = exp_lines.pop_front();
                eg = exp_gap.pop_front();
                et = exp_tag.pop_front();
                check(clk_lines == el, {et, " lines"}, int'(clk_lines), int'(el));
                check(since == eg, {et, " spacing"}, since, eg);
            end
            since = 0;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) fmem[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(running == 1'b0 && bus_drv == 1'b0 && fifo_rd == 1'b0, "R1 idle outputs",
              int'({running, bus_drv, fifo_rd}), 0);
        check(strobe == 1'b0 && uflow_err == 1'b0, "R1 strobe/err", int'({strobe, uflow_err}), 0);
        rst_n = 1'b1;
        xt_en = 1'b1;

        // T1: plain patterns, unknown opcode, ignored go
        acc = 2;
        add_pat(12'hA5A, 3, "R3");
        add_pat(12'h123, 1, "R3");
        add_op(4'd7, 1);                 // R11 skipped word
        add_pat(12'hFFF, 0, "R11");
        add_pat(12'h001, 5, "R3");
        add_op(4'd3, 0);
        repeat (6) @(negedge clk);
        check(rp == 0, "R2 no read before go", rp, 0);
        start;
        @(negedge clk);
        go = 1'b1;                       // R2 go while running is ignored
        @(negedge clk);
        go = 1'b0;
        wait_idle;
        repeat (4) @(negedge clk);
        check(exp_lines.size() == 0, "R3 all patterns seen", exp_lines.size(), 0);
        check(rp == wp, "R2 words consumed", rp, wp);

        // T2: repeated rendezvous with phase delay 3
        phase_dly = 16'd3;
        acc = 2;
        add_pat(12'h111, 2, "R6");
        add_op(4'd1, 1);
        add_op(4'd2, SYNC + 2 + 3);
        add_pat(12'h222, 2, "R10");
        add_op(4'd1, 1);
        add_op(4'd2, SYNC + 2 + 3);
        add_pat(12'h333, 1, "R10");
        add_op(4'd1, 1);
        add_op(4'd2, SYNC + 2 + 3);
        add_pat(12'h444, 1, "R10");
        add_op(4'd1, 1);
        add_op(4'd3, 0);
        start;
        wait_idle;
        repeat (3) @(negedge clk);
        check(exp_lines.size() == 0, "R10 rendezvous patterns seen", exp_lines.size(), 0);
        check(bus_drv == 1'b1, "R4 drive after NOTDONE kept over END (R8)", bus_drv, 1);

        // T3: another participant holds the line, then releases
        phase_dly = '0;
        others = 3'b010;
        acc = 2;
        add_pat(12'h0AA, 1, "R5");
        push_word({4'd2, 28'd0});
        push_word({4'd0, 12'h0BB, 16'd1});
        exp_lines.push_back(12'h0BB);
        exp_gap.push_back(SYNC + 2);
        exp_tag.push_back("R5 after release");
        push_word({4'd3, 28'd0});
        push_word({4'd1, 28'd0});
        push_word({4'd0, 12'h0CC, 16'd1});
        start;
        repeat (30) @(negedge clk);
        check(bus_drv == 1'b0, "R5 own drive dropped", bus_drv, 0);
        check(exp_lines.size() == 1, "R5 stalled while line busy", exp_lines.size(), 1);
        check(rp == wp - 4, "R5 no read while stalled", rp, wp - 4);
        others = 3'b000;
        since = 0;
        wait_idle;
        repeat (10) @(negedge clk);
        check(exp_lines.size() == 0, "R5 released pattern seen", exp_lines.size(), 0);
        check(rp == wp - 2, "R8 words after END unread", rp, wp - 2);
        check(running == 1'b0, "R8 idle after END", running, 0);

        // T4: underflow
        acc = 3;
        exp_lines.push_back(12'h0CC);
        exp_gap.push_back(acc);
        exp_tag.push_back("R9");
        start;
        repeat (12) @(negedge clk);
        check(uflow_err == 1'b1, "R9 underflow flag", uflow_err, 1);
        check(running == 1'b1, "R9 stopped not idle", running, 1);
        check(bus_drv == 1'b1, "R9 drive held", bus_drv, 1);
        check(exp_lines.size() == 0, "R9 last pattern seen", exp_lines.size(), 0);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        check(uflow_err == 1'b1 && running == 1'b1, "R9 sticky, go ignored",
              int'({uflow_err, running}), 3);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(uflow_err == 1'b0 && running == 1'b0, "R9 cleared to idle",
              int'({uflow_err, running}), 0);

        // T5: enable off
        xt_en = 1'b0;
        others = 3'b101;
        phase_dly = 16'd5;
        @(negedge clk);
        check(bus_drv == 1'b0, "R7 drive gated", bus_drv, 0);
        acc = 2;
        add_op(4'd1, 1);
        add_pat(12'h5A5, 2, "R7");
        add_op(4'd1, 1);
        add_op(4'd2, 1);
        add_pat(12'h0F0, 1, "R7 no stall");
        add_op(4'd3, 0);
        start;
        begin
            int bad = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (bus_drv) bad++;
            end
            check(bad == 0, "R7 drive never high", bad, 0);
        end
        check(running == 1'b0, "R7 sequence ended", running, 0);
        check(exp_lines.size() == 0, "R7 patterns seen", exp_lines.size(), 0);
        others = '0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule